// File: doc/BRIEF.md
# Planar Routing Switch Box

This block is the programmable switch found at each crossing of a horizontal and a vertical routing channel in an island-style logic fabric. Four sides meet at the crossing: north, east, south and west. Each side carries `W` tracks, and each track has a data input, a drive-enable and a data output. Routing is restricted per track. Track k on one side can reach only track k on the other three sides. Each track therefore has six pairwise switches, one for every pair of sides, and the block holds no crossbar between track indices.

The switch settings live in a configuration register of `6*W` bits that is filled through a serial shift chain. For each track the block closes the selected switches and works out which sides form one connected group. Connection is transitive, so a path through a third side also joins two sides. Every side of the group then sees the value put on the group by its enabled driver. A group with no driver reads 0. A group with more than one driver raises that track's contention flag, and its outputs carry the OR of all the drivers.

Longer routes are built outside this block by closing switches in a chain of boxes, because each wire segment ends at the next box. While the chain is shifting, the routing outputs stay silent.

Top module: `sbox_planar_switch`

## Requirements
- R1: A synchronous reset opens every switch. Afterwards each side of a track sees only its own driven value (input when enabled, else 0), `cfg_out` is 0 and no contention is flagged.
- R2: With `cfg_en` high, each rising clock edge shifts `cfg_in` into the chain. The bits load track 0 first. Within a track the switch order is N-E, N-S, N-W, E-S, E-W, S-W, so the switch for track t and pair p is load bit number 6t+p. `cfg_out` presents the oldest bit in the chain, which means the bit loaded first appears there after `6*W` shifts.
- R3: A closed switch joins its two sides. The value of an enabled driver on either side appears on both sides' outputs for that track, including the driving side itself.
- R4: Joining is transitive. With N-E and E-S closed and N-S open, a driver on N reaches S, while W stays unconnected.
- R5: Track k never connects to any other track index. A driver on one track leaves the outputs of every other track unchanged.
- R6: Every output of a group that has no enabled driver is 0, whatever the data inputs carry.
- R7: When two or more sides of one connected group assert drive-enable, that track's `contention` bit is 1 and the group's outputs equal the OR of the driven values.
- R8: Two drivers on the same track but in separate groups raise no contention. Each group carries only its own driver's value.
- R9: While `cfg_en` is high, all data outputs and all `contention` bits are 0.
- R10: While `cfg_en` is low, the configuration is held unchanged, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (oldest bit) |
| n_in | input | W | North data per track |
| n_oe | input | W | North drive-enable per track |
| n_out | output | W | North resolved value per track |
| e_in | input | W | East data per track |
| e_oe | input | W | East drive-enable per track |
| e_out | output | W | East resolved value per track |
| s_in | input | W | South data per track |
| s_oe | input | W | South drive-enable per track |
| s_out | output | W | South resolved value per track |
| w_in | input | W | West data per track |
| w_oe | input | W | West drive-enable per track |
| w_out | output | W | West resolved value per track |
| contention | output | W | Per track: more than one driver in one group |

## Verification
The hardest case to reach from the ports is a group that exists only through transitivity. Such a group needs a chosen subset of the six bits of one track, set at known chain positions, while the direct switch stays open. The stimulus shifts in whole hand-built patterns and then drives single sides so that the bench can see where each value arrives. The bench confirms the chain order by shifting a known pattern back out through `cfg_out`. It also checks that outputs go silent by raising `cfg_en` mid-traffic, when a contended group is active.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
   localparam int SIDES = 4;
   localparam int PAIRS = 6;

   typedef enum logic [1:0] {SIDE_N = 2'd0, SIDE_E = 2'd1, SIDE_S = 2'd2, SIDE_W = 2'd3} side_e;

   typedef logic [SIDES-1:0][SIDES-1:0] reach_t;

   // first side of switch pair p (pair order N-E, N-S, N-W, E-S, E-W, S-W)
   function automatic side_e pair_lo(input int p);
      case (p)
         0, 1, 2: return SIDE_N;
         3, 4:    return SIDE_E;
         default: return SIDE_S;
      endcase
   endfunction

   function automatic side_e pair_hi(input int p);
      case (p)
         0:       return SIDE_E;
         1, 3:    return SIDE_S;
         default: return SIDE_W;
      endcase
   endfunction

   // transitive closure of the four-node graph of one track
   function automatic reach_t link_closure(input logic [PAIRS-1:0] sw);
      reach_t r;
      r = '0;
      for (int i = 0; i < SIDES; i++) r[i][i] = 1'b1;
      for (int p = 0; p < PAIRS; p++) begin
         r[pair_lo(p)][pair_hi(p)] = r[pair_lo(p)][pair_hi(p)] | sw[p];
         r[pair_hi(p)][pair_lo(p)] = r[pair_hi(p)][pair_lo(p)] | sw[p];
      end
      for (int k = 0; k < SIDES; k++)
         for (int i = 0; i < SIDES; i++)
            for (int j = 0; j < SIDES; j++)
               r[i][j] = r[i][j] | (r[i][k] & r[k][j]);
      return r;
   endfunction
endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain
   import sbox_pkg::*;
#(
   parameter int W = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      shift_en,
   input  logic                      shift_in,
   output logic                      shift_out,
   output logic [W-1:0][PAIRS-1:0]   sw_bits
);
   localparam int NB = PAIRS * W;

   logic [NB-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst)           chain_q <= '0;
      else if (shift_en) chain_q <= {chain_q[NB-2:0], shift_in};
   end

   assign shift_out = chain_q[NB-1];

   // the bit shifted in first sits at the top of the chain after NB shifts
   for (genvar t = 0; t < W; t++) begin : g_trk
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         assign sw_bits[t][p] = chain_q[NB-1-(PAIRS*t+p)];
      end
   end

   assert_cfg_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (chain_q == '0));

   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/sbox_track_net.sv
module sbox_track_net
   import sbox_pkg::*;
(
   input  logic [PAIRS-1:0] sw,
   input  logic [SIDES-1:0] drv_val,
   input  logic [SIDES-1:0] drv_en,
   input  logic             quiet,
   output logic [SIDES-1:0] val_out,
   output logic             clash
);
   reach_t reach;

   always_comb begin
      logic       grp_val;
      logic [2:0] grp_cnt;
      logic       any_clash;
      reach     = link_closure(sw);
      any_clash = 1'b0;
      val_out   = '0;
      for (int s = 0; s < SIDES; s++) begin
         grp_val = 1'b0;
         grp_cnt = 3'd0;
         for (int t = 0; t < SIDES; t++) begin
            if (reach[s][t] && drv_en[t]) begin
               grp_val = grp_val | drv_val[t];
               grp_cnt = grp_cnt + 3'd1;
            end
         end
         val_out[s] = grp_val & ~quiet;
         if (grp_cnt >= 3'd2) any_clash = 1'b1;
      end
      clash = any_clash & ~quiet;
   end
endmodule

// File: rtl/sbox_planar_switch.sv
module sbox_planar_switch
   import sbox_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cfg_en,
   input  logic         cfg_in,
   output logic         cfg_out,
   input  logic [W-1:0] n_in,
   input  logic [W-1:0] n_oe,
   output logic [W-1:0] n_out,
   input  logic [W-1:0] e_in,
   input  logic [W-1:0] e_oe,
   output logic [W-1:0] e_out,
   input  logic [W-1:0] s_in,
   input  logic [W-1:0] s_oe,
   output logic [W-1:0] s_out,
   input  logic [W-1:0] w_in,
   input  logic [W-1:0] w_oe,
   output logic [W-1:0] w_out,
   output logic [W-1:0] contention
);
   if (W < 1) begin : g_bad_width
      $error("sbox_planar_switch: W must be at least 1");
   end

   logic [W-1:0][PAIRS-1:0] sw_bits;

   sbox_cfg_chain #(.W(W)) u_chain (
      .clk       (clk),
      .rst       (rst),
      .shift_en  (cfg_en),
      .shift_in  (cfg_in),
      .shift_out (cfg_out),
      .sw_bits   (sw_bits)
   );

   for (genvar t = 0; t < W; t++) begin : g_track
      logic [SIDES-1:0] res;

      sbox_track_net u_net (
         .sw      (sw_bits[t]),
         .drv_val ({w_in[t], s_in[t], e_in[t], n_in[t]}),
         .drv_en  ({w_oe[t], s_oe[t], e_oe[t], n_oe[t]}),
         .quiet   (cfg_en),
         .val_out (res),
         .clash   (contention[t])
      );

      assign n_out[t] = res[SIDE_N];
      assign e_out[t] = res[SIDE_E];
      assign s_out[t] = res[SIDE_S];
      assign w_out[t] = res[SIDE_W];

      assert_contend_drivers_R7: assert property (@(posedge clk) disable iff (rst)
         contention[t] |-> ($countones({w_oe[t], s_oe[t], e_oe[t], n_oe[t]}) >= 2));

      assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
         ({w_oe[t], s_oe[t], e_oe[t], n_oe[t]} == 4'b0000)
         |-> ({w_out[t], s_out[t], e_out[t], n_out[t]} == 4'b0000));
   end

   assert_quiet_cfg_R9: assert property (@(posedge clk) disable iff (rst)
      cfg_en |-> ((n_out | e_out | s_out | w_out | contention) == '0));
endmodule

// File: tb/sbox_planar_switch_test.sv
module sbox_planar_switch_test;
   localparam int CLK_PERIOD = 10;
   localparam int BW = 4;
   localparam int NB = 6 * BW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_en = 1'b0;
   logic cfg_in = 1'b0;
   logic cfg_out;
   logic [BW-1:0] n_in = '0, n_oe = '0, n_out;
   logic [BW-1:0] e_in = '0, e_oe = '0, e_out;
   logic [BW-1:0] s_in = '0, s_oe = '0, s_out;
   logic [BW-1:0] w_in = '0, w_oe = '0, w_out;
   logic [BW-1:0] contention;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sbox_planar_switch #(.W(BW)) uut (
      .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
      .n_in(n_in), .n_oe(n_oe), .n_out(n_out),
      .e_in(e_in), .e_oe(e_oe), .e_out(e_out),
      .s_in(s_in), .s_oe(s_oe), .s_out(s_out),
      .w_in(w_in), .w_oe(w_oe), .w_out(w_out),
      .contention(contention)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      n_in = '0; n_oe = '0; e_in = '0; e_oe = '0;
      s_in = '0; s_oe = '0; w_in = '0; w_oe = '0;
   endtask

   // v[6*t+p] is switch p of track t; v[0] is shifted first
   task automatic load_cfg(input logic [NB-1:0] v);
      for (int i = 0; i < NB; i++) begin
         @(negedge clk);
         cfg_en = 1'b1;
         cfg_in = v[i];
      end
      @(negedge clk);
      cfg_en = 1'b0;
      cfg_in = 1'b0;
      #1;
   endtask

   task automatic test_reset_R1();
      idle_inputs();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1 cfg_out", cfg_out, 1'b0);
      n_in = 4'b1111; n_oe = 4'b1111;
      #1;
      check("R1 n_out own", n_out, 4'b1111);
      check("R1 e_out open", {e_out, s_out, w_out}, 12'h000);
      check("R1 contention", contention, 4'b0000);
      idle_inputs();
   endtask

   task automatic test_direct_R3();
      logic [NB-1:0] v = '0;
      v[0] = 1'b1;                     // track 0 N-E
      load_cfg(v);
      n_in[0] = 1'b1; n_oe[0] = 1'b1;
      #1;
      check("R3 N->E", e_out[0], 1'b1);
      check("R3 driver sees own", n_out[0], 1'b1);
      check("R3 S,W untouched", {s_out[0], w_out[0]}, 2'b00);
      idle_inputs();
      e_in[0] = 1'b1; e_oe[0] = 1'b1;
      #1;
      check("R3 E->N", n_out[0], 1'b1);
      e_in[0] = 1'b0;
      #1;
      check("R3 driven zero", {n_out[0], e_out[0]}, 2'b00);
      idle_inputs();
   endtask

   task automatic test_transitive_R4_R5();
      logic [NB-1:0] v = '0;
      v[6*1+0] = 1'b1;                 // track 1 N-E
      v[6*1+3] = 1'b1;                 // track 1 E-S
      load_cfg(v);
      n_in[1] = 1'b1; n_oe[1] = 1'b1;
      #1;
      check("R4 N reaches S", s_out[1], 1'b1);
      check("R4 N reaches E", e_out[1], 1'b1);
      check("R4 W isolated", w_out[1], 1'b0);
      n_in = 4'b1101; n_oe = 4'b1101;  // tracks 0, 2, 3 driven, all open there
      #1;
      check("R5 other tracks E", e_out, 4'b0000);
      check("R5 other tracks S", s_out, 4'b0000);
      idle_inputs();
   endtask

   task automatic test_idle_contend_R6_R7_R8();
      logic [NB-1:0] v = '0;
      for (int p = 0; p < 6; p++) v[6*2+p] = 1'b1;   // track 2 fully joined
      v[6*3+0] = 1'b1;                 // track 3 N-E
      v[6*3+5] = 1'b1;                 // track 3 S-W
      load_cfg(v);
      n_in[2] = 1'b1; e_in[2] = 1'b1; s_in[2] = 1'b1; w_in[2] = 1'b1;
      #1;
      check("R6 undriven group", {n_out[2], e_out[2], s_out[2], w_out[2]}, 4'b0000);
      idle_inputs();
      n_in[2] = 1'b1; n_oe[2] = 1'b1;
      w_in[2] = 1'b0; w_oe[2] = 1'b1;
      #1;
      check("R7 contention flag", contention, 4'b0100);
      check("R7 OR of drivers", {n_out[2], e_out[2], s_out[2], w_out[2]}, 4'b1111);
      idle_inputs();
      n_in[3] = 1'b1; n_oe[3] = 1'b1;
      s_in[3] = 1'b0; s_oe[3] = 1'b1;
      #1;
      check("R8 separate groups", contention, 4'b0000);
      check("R8 group values", {e_out[3], w_out[3]}, 2'b10);
      idle_inputs();
   endtask

   task automatic test_readback_R2_R10();
      logic [NB-1:0] v = 24'hA5_3C_96;
      load_cfg(v);
      for (int k = 0; k < 8; k++) begin       // traffic while not shifting
         @(negedge clk);
         n_in = 4'(k); n_oe = 4'(~k); s_in = 4'(k * 3); w_oe = 4'(k);
      end
      idle_inputs();
      begin
         int mism = 0;
         for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_in = 1'b0;
            #1;
            if (cfg_out !== v[i]) mism++;
         end
         check("R2/R10 chain readback order", mism, 0);
      end
      @(negedge clk);
      cfg_en = 1'b0;
      #1;
      check("R2 chain drained", cfg_out, 1'b0);
   endtask

   task automatic test_quiet_R9();
      logic [NB-1:0] v = '0;
      for (int p = 0; p < 6; p++) v[6*2+p] = 1'b1;
      load_cfg(v);
      n_in[2] = 1'b1; n_oe[2] = 1'b1; e_in[2] = 1'b1; e_oe[2] = 1'b1;
      #1;
      check("R9 active before", {contention[2], w_out[2]}, 2'b11);
      @(negedge clk);
      cfg_en = 1'b1;
      #1;
      check("R9 outputs silent", {n_out, e_out, s_out, w_out}, 16'h0000);
      check("R9 contention silent", contention, 4'b0000);
      @(negedge clk);
      cfg_en = 1'b0;
      idle_inputs();
   endtask

   initial begin
      test_reset_R1();
      test_direct_R3();
      test_transitive_R4_R5();
      test_idle_contend_R6_R7_R8();
      test_readback_R2_R10();
      test_quiet_R9();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule